// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a page table entry by reading memory. A walk starts at a context table and can then pass through up to three levels of directory tables. Each level costs one 32-bit read on a simple request/acknowledge memory port. The walker takes four inputs when a walk starts: a context table pointer, a context number, the virtual address and a 3-bit access type.

A walk ends in one of two ways. On success the block returns the leaf entry and the level where it was found. On failure it returns a fault code that names the level where the walk stopped, the access type and the kind of fault. Either outcome is reported with a single-cycle completion pulse.

The block does no caching and no permission checking. It also never writes back referenced or modified bits. A requester pulses `start` while the block is idle and waits for `done`.

Top module: `ptw_top`

## Requirements
- R1: The first read of a walk (level 0) goes to address `(ctx_table_ptr << 4) + (ctx_num << 4)`, taken modulo 2^32.
- R2: The table base for level N+1 is `(word & ~3) << 4`, where `word` is the directory entry read at level N. The read address at a level is that base plus a byte offset taken from the virtual address:
  - level 1 uses `vaddr[31:24]*4`
  - level 2 uses `vaddr[23:18]*4`
  - level 3 uses `vaddr[17:12]*4`
- R3: Bits 1:0 of each fetched word give its kind: 0 invalid, 1 directory, 2 leaf, 3 reserved. A leaf at level 1, 2 or 3 ends the walk with success. In that case `fault` is 0, `pte` equals the fetched word, `pte_level` equals the level and `fault_code` is 0.
- R4: An invalid word at any level ends the walk with `fault`=1 and fault type 1, tagged with that level.
- R5: The walk ends with `fault`=1 and fault type 4 in three cases: a leaf at level 0, a reserved word at any level, or a directory word at level 3.
- R6: The fault code is laid out as follows: bits 9:8 hold the stop level, bits 7:5 hold the access type latched at start, bits 4:2 hold the fault type, and bits 1:0 are zero. On a fault, `pte` reads 0.
- R7: Once `mem_req` is asserted, it stays high and `mem_addr` stays unchanged until the cycle in which `mem_ack` is seen.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the clock edge that sampled the final `mem_ack`.
- R9: `busy` is high from the edge that accepts `start` until `done` rises. A `start` seen while busy is ignored, and the walk in progress continues with its latched inputs.
- R10: After a synchronous reset, `busy`, `mem_req` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ctx_table_ptr | input | 32 | Context table pointer |
| ctx_num | input | 32 | Context number |
| vaddr | input | 32 | Virtual address to translate |
| access_type | input | 3 | Access type, copied into the fault code |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completed walk faulted |
| pte | output | 32 | Leaf entry on success, 0 on fault |
| pte_level | output | 2 | Level where the leaf was found |
| fault_code | output | 10 | Level, access type and fault type |

## Verification
The hardest outcomes to reach are the deep ones: a reserved, invalid or directory word at level 3. They need three well-formed directory entries in a row, each pointing at the next table. The bench plays the memory. For every stop level and entry kind, it builds the chain of directory words ahead of the stop point and checks each requested address against the arithmetic from R1 and R2. It varies the acknowledge latency from zero to two cycles. During the wait cycles it pulses `start` with junk inputs, so any start that was wrongly accepted would show up as a wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int LVL_W    = 2;
    localparam int ACC_W    = 3;
    localparam int FTYPE_W  = 3;
    localparam int CODE_W   = LVL_W + ACC_W + FTYPE_W + 2;
    localparam int PTR_SHIFT = 4;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(3);

    typedef enum logic [1:0] {
        ENT_INVALID = 2'd0,
        ENT_DIR     = 2'd1,
        ENT_LEAF    = 2'd2,
        ENT_RSVD    = 2'd3
    } ent_kind_e;

    typedef enum logic [FTYPE_W-1:0] {
        FT_NONE    = 3'd0,
        FT_INVALID = 3'd1,
        FT_XLATE   = 3'd4
    } ftype_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic   descend;
        logic   is_fault;
        ftype_e ftype;
    } verdict_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] root;
        logic [ACC_W-1:0]  acc;
    } walk_req_t;

    function automatic logic [ADDR_W-1:0] next_base(input logic [DATA_W-1:0] word);
        logic [DATA_W-1:0] w;
        w = word & ~DATA_W'(3);
        return ADDR_W'(w << PTR_SHIFT);
    endfunction

    function automatic logic [ADDR_W-1:0] root_addr(input logic [ADDR_W-1:0] ptr,
                                                    input logic [ADDR_W-1:0] num);
        return (ptr << PTR_SHIFT) + (num << PTR_SHIFT);
    endfunction

    function automatic logic [CODE_W-1:0] pack_fault(input logic [LVL_W-1:0] lvl,
                                                     input logic [ACC_W-1:0] acc,
                                                     input ftype_e ft);
        return {lvl, acc, ft, 2'b00};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [AW-1:0]    root,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    vaddr,
    output logic [AW-1:0]    addr
);
    localparam int NLVL = 4;

    logic [AW-1:0] offs [NLVL];

    // Level 0 has no index slice; levels 1..3 take successively lower slices.
    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_off
            if (g == 0) begin : g_root
                assign offs[g] = '0;
            end else if (g == 1) begin : g_l1
                assign offs[g] = AW'({vaddr[31:24], 2'b00});
            end else if (g == 2) begin : g_l2
                assign offs[g] = AW'({vaddr[23:18], 2'b00});
            end else begin : g_l3
                assign offs[g] = AW'({vaddr[17:12], 2'b00});
            end
        end
    endgenerate

    always_comb begin
        if (lvl == '0) addr = root;
        else           addr = base + offs[lvl];
    end
endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
    import ptw_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [LVL_W-1:0]  lvl,
    output verdict_t          verdict
);
    ent_kind_e kind;

    always_comb begin
        kind = ent_kind_e'(word[1:0]);
        verdict.descend  = 1'b0;
        verdict.is_fault = 1'b1;
        verdict.ftype    = FT_XLATE;
        unique case (kind)
            ENT_INVALID: verdict.ftype = FT_INVALID;
            ENT_DIR: begin
                if (lvl != LAST_LVL) begin
                    verdict.descend  = 1'b1;
                    verdict.is_fault = 1'b0;
                    verdict.ftype    = FT_NONE;
                end
            end
            ENT_LEAF: begin
                if (lvl != '0) begin
                    verdict.is_fault = 1'b0;
                    verdict.ftype    = FT_NONE;
                end
            end
            ENT_RSVD: verdict.ftype = FT_XLATE;
            default:  verdict.ftype = FT_XLATE;
        endcase
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  walk_req_t         req_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  verdict_t          verdict,
    output logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] base,
    output walk_req_t         req_q,
    output logic              fetching,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] pte,
    output logic [LVL_W-1:0]  pte_level,
    output logic [CODE_W-1:0] fault_code
);
    walk_state_e st;
    logic        fire;

    assign fetching = (st == ST_FETCH);
    assign fire     = fetching && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            lvl        <= '0;
            base       <= '0;
            req_q      <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            pte        <= '0;
            pte_level  <= '0;
            fault_code <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        lvl   <= '0;
                        base  <= '0;
                        st    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fire) begin
                        if (verdict.descend) begin
                            lvl  <= lvl + LVL_W'(1);
                            base <= next_base(mem_rdata);
                        end else begin
                            st    <= ST_IDLE;
                            done  <= 1'b1;
                            fault <= verdict.is_fault;
                            if (verdict.is_fault) begin
                                pte        <= '0;
                                pte_level  <= '0;
                                fault_code <= pack_fault(lvl, req_q.acc, verdict.ftype);
                            end else begin
                                pte        <= mem_rdata;
                                pte_level  <= lvl;
                                fault_code <= '0;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       ctx_table_ptr,
    input  logic [31:0]       ctx_num,
    input  logic [31:0]       vaddr,
    input  logic [2:0]        access_type,
    output logic              busy,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [31:0]       pte,
    output logic [1:0]        pte_level,
    output logic [9:0]        fault_code
);
    walk_req_t         req_in;
    walk_req_t         req_q;
    verdict_t          verdict;
    logic [LVL_W-1:0]  lvl;
    logic [ADDR_W-1:0] base;
    logic              fetching;

    always_comb begin
        req_in.vaddr = vaddr;
        req_in.root  = root_addr(ctx_table_ptr, ctx_num);
        req_in.acc   = access_type;
    end

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_in     (req_in),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .verdict    (verdict),
        .lvl        (lvl),
        .base       (base),
        .req_q      (req_q),
        .fetching   (fetching),
        .done       (done),
        .fault      (fault),
        .pte        (pte),
        .pte_level  (pte_level),
        .fault_code (fault_code)
    );

    ptw_classify u_cls (
        .word    (mem_rdata),
        .lvl     (lvl),
        .verdict (verdict)
    );

    ptw_addr_gen #(.AW(ADDR_W)) u_agen (
        .lvl   (lvl),
        .root  (req_q.root),
        .base  (base),
        .vaddr (req_q.vaddr),
        .addr  (mem_addr)
    );

    assign mem_req = fetching;
    assign busy    = fetching;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [31:0] pte,
    input logic [1:0]  pte_level,
    input logic [9:0]  fault_code
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_ack_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_req && mem_ack));

    assert_req_within_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_leaf_result_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (pte[1:0] == 2'd2 && pte_level != 2'd0 && fault_code == 10'd0));

    assert_fault_type_R6: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> ((fault_code[4:2] == 3'd1 || fault_code[4:2] == 3'd4)
                             && fault_code[1:0] == 2'b00 && pte == 32'd0));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_req && !done));
endmodule

bind ptw_top ptw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .done       (done),
    .fault      (fault),
    .pte        (pte),
    .pte_level  (pte_level),
    .fault_code (fault_code)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ctx_table_ptr = '0;
    logic [31:0] ctx_num = '0;
    logic [31:0] vaddr = '0;
    logic [2:0]  access_type = '0;
    logic        busy, mem_req, done, fault;
    logic [31:0] mem_addr, pte;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  pte_level;
    logic [9:0]  fault_code;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptw_top u_dut (
        .clk(clk), .rst(rst), .start(start),
        .ctx_table_ptr(ctx_table_ptr), .ctx_num(ctx_num), .vaddr(vaddr),
        .access_type(access_type), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .pte(pte), .pte_level(pte_level),
        .fault_code(fault_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One walk: levels before stop_lvl return directory words, stop_lvl returns kind stop_ty.
    task automatic run_case(input int n, input int stop_lvl, input int stop_ty, input int lat);
        logic [31:0] cp, cn, va, word, exp_addr, base, hi;
        logic [2:0]  acc;
        logic [2:0]  exp_ft;
        bit          exp_fault;
        cp  = 32'h0001_0000 + 32'(n) * 32'h0919_2837;
        cn  = 32'(n) * 32'd3 + 32'h0FFF_FFF0 * 32'(n % 2);
        va  = 32'hA5C3_7000 ^ (32'(n) * 32'h0123_4567);
        acc = 3'(n % 8);
        @(negedge clk);
        ctx_table_ptr = cp; ctx_num = cn; vaddr = va; access_type = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base = '0;
        for (int l = 0; l <= stop_lvl; l++) begin
            // R1 / R2 expected address
            if (l == 0)      exp_addr = (cp << 4) + (cn << 4);
            else if (l == 1) exp_addr = base + ((va >> 24) & 32'hFF) * 4;
            else if (l == 2) exp_addr = base + ((va >> 18) & 32'h3F) * 4;
            else             exp_addr = base + ((va >> 12) & 32'h3F) * 4;
            hi = (32'(n) * 32'h2468_ACE1 + 32'(l) * 32'h0001_1110) & ~32'h3;
            word = (l == stop_lvl) ? (hi | 32'(stop_ty)) : (hi | 32'd1);
            for (int w = 0; w <= lat; w++) begin
                chk(mem_req === 1'b1, $sformatf("R7 req held lvl%0d", l), 32'(mem_req), 32'd1);
                chk(busy === 1'b1, "R9 busy during walk", 32'(busy), 32'd1);
                chk(mem_addr === exp_addr, (l == 0) ? "R1 root address" : "R2 level address",
                    mem_addr, exp_addr);
                if (w < lat) begin
                    // R9: junk start while busy must be ignored
                    start = 1'b1; vaddr = ~va; ctx_table_ptr = ~cp; access_type = ~acc;
                    @(negedge clk);
                end else begin
                    start = 1'b0;
                    mem_ack = 1'b1; mem_rdata = word;
                    @(negedge clk);
                    mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
                end
            end
            base = (word & ~32'h3) << 4;
            if (l < stop_lvl)
                chk(done === 1'b0, "R8 no done mid-walk", 32'(done), 32'd0);
        end
        // outcome
        exp_fault = 1'b1;
        exp_ft = 3'd4;
        if (stop_ty == 0) exp_ft = 3'd1;
        else if (stop_ty == 2 && stop_lvl != 0) begin exp_fault = 1'b0; exp_ft = 3'd0; end
        chk(done === 1'b1, "R8 done after last ack", 32'(done), 32'd1);
        chk(fault === exp_fault, (stop_ty == 0) ? "R4 fault flag" : "R5 fault flag",
            32'(fault), 32'(exp_fault));
        if (exp_fault) begin
            chk(fault_code === {2'(stop_lvl), acc, exp_ft, 2'b00},
                (stop_ty == 0) ? "R4 invalid code" : "R5 R6 translation code",
                32'(fault_code), 32'({2'(stop_lvl), acc, exp_ft, 2'b00}));
            chk(pte === 32'd0, "R6 pte zero on fault", pte, 32'd0);
        end else begin
            chk(pte === word, "R3 leaf word", pte, word);
            chk(pte_level === 2'(stop_lvl), "R3 leaf level", 32'(pte_level), 32'(stop_lvl));
            chk(fault_code === 10'd0, "R3 code zero", 32'(fault_code), 32'd0);
        end
        @(negedge clk);
        chk(done === 1'b0, "R8 single-cycle done", 32'(done), 32'd0);
        chk(busy === 1'b0 && mem_req === 1'b0, "R9 idle after walk", 32'({busy, mem_req}), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R10 reset state",
            32'({busy, mem_req, done}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R10 idle after reset", 32'({busy, mem_req}), 32'd0);
        for (int lv = 0; lv < 4; lv++) begin
            for (int ty = 0; ty < 4; ty++) begin
                if (ty == 1 && lv < 3) continue;
                for (int lat = 0; lat < 3; lat++) begin
                    run_case(n, lv, ty, lat);
                    n++;
                end
            end
        end
        // reset in mid-walk returns to idle (R10)
        @(negedge clk);
        start = 1'b1; ctx_table_ptr = 32'h10; ctx_num = 32'h2; vaddr = 32'h1234_5000;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R10 reset aborts walk", 32'({busy, mem_req}), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule